// File: doc/BRIEF.md
# Horizontal Running-Sum Window Filter

This block computes a horizontal moving sum over a stream of pixel samples. Each accepted sample is added to a running total for the current scan line. A circular store keeps the totals from earlier samples. Each output is the newest total minus the total recorded a window length earlier. The cost per pixel is one add and one subtract for any window length, and the window length only sets the depth of the store.

A start-of-line pulse clears the running total and the store's fill count, so a window never reaches back into the previous line. Until a full window of samples has entered the new line, nothing is subtracted and the output is the sum of the samples seen so far. The block sums only. Dividing by the window length to get an average is left to the consumer. Vertical filtering, which would need a buffer one scan line long, is not part of this block.

Top module: `boxcar_line_filter`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `sumValid` is 0 and `sumOut` is 0.
- R2: `sumValid` equals the value `sampleValid` had one clock earlier; each accepted sample yields exactly one result, in arrival order.
- R3: For the first WINDOW-1 accepted samples of a line, `sumOut` is the sum of all samples accepted so far in that line. The first sample after a line start gives its own value.
- R4: From the WINDOW-th accepted sample of a line onward, `sumOut` is the sum of the last WINDOW accepted samples, so it never exceeds WINDOW times the largest sample value.
- R5: Cycles with `sampleValid` low do not change the running total or the stored totals; results after a gap equal those without the gap.
- R6: When `lineStart` and `sampleValid` are high in the same cycle, the line is cleared first and that sample becomes the first sample of the new line.
- R7: A `lineStart` with `sampleValid` low produces no result and clears the line; the next accepted sample starts a fresh window.
- R8: `sumOut` holds its value in every cycle in which `sumValid` is low.
- R9: Results stay correct when the running total wraps, including lines longer than LINE_MAX samples, because the subtraction is modular.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | SAMPLE_W | Incoming pixel sample, unsigned |
| sampleValid | input | 1 | Marks `sampleIn` as a sample to accept |
| lineStart | input | 1 | Pulse marking the start of a scan line |
| sumOut | output | SAMPLE_W+clog2(WINDOW) | Sum over the current window |
| sumValid | output | 1 | `sumOut` carries a new result |

## Verification
The line clear and the acceptance of a sample can fall in the same cycle. The clear must take effect first, so that the sample starts the new line rather than extending the old one. The bench provokes this by raising `lineStart` together with `sampleValid` in the middle of a long stream, after the window has filled with large values. The scoreboard checks that this sample comes back as its own value, and that the following results are partial sums over the new line only. It also checks a lone `lineStart` with no sample and gaps inside a window, which must leave every later result unchanged.

// File: rtl/boxcar_pkg.sv
package boxcar_pkg;

  // Strobes from the control to the datapath, one set per cycle
  typedef struct packed {
    logic push;        // accept the sample on sampleIn
    logic clearLine;   // restart the running total and store pointer
    logic useDelayed;  // a full window is present: subtract the delayed total
  } boxStrobe_t;

endpackage

// File: rtl/boxcar_ctrl.sv
module boxcar_ctrl
  import boxcar_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleValid,
  input  logic       lineStart,
  output boxStrobe_t strobe
);

  localparam int FILL_W = $clog2(WINDOW + 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(WINDOW);

  // number of samples accepted in this line, saturating at WINDOW
  logic [FILL_W-1:0] fillCnt;

  always_comb begin
    strobe.push       = sampleValid;
    strobe.clearLine  = lineStart;
    strobe.useDelayed = !lineStart && (fillCnt == FILL_FULL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt <= '0;
    end else if (lineStart) begin
      fillCnt <= sampleValid ? FILL_W'(1) : '0;
    end else if (sampleValid && fillCnt != FILL_FULL) begin
      fillCnt <= fillCnt + FILL_W'(1);
    end
  end

endmodule

// File: rtl/boxcar_dpath.sv
module boxcar_dpath
  import boxcar_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int WINDOW   = 4,
  parameter int ACC_W    = 18,
  parameter int SUM_W    = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  boxStrobe_t          strobe,
  output logic [SUM_W-1:0]    sumOut,
  output logic                sumValid
);

  localparam int PTR_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(WINDOW - 1);

  logic [ACC_W-1:0] runTotal;
  logic [ACC_W-1:0] delayStore [WINDOW];
  logic [PTR_W-1:0] slotPtr;

  logic [ACC_W-1:0] baseTotal;
  logic [ACC_W-1:0] nextTotal;
  logic [ACC_W-1:0] delayedTotal;
  logic [ACC_W-1:0] windowDiff;
  logic [PTR_W-1:0] basePtr;
  logic [PTR_W-1:0] nextPtr;

  always_comb begin
    baseTotal    = strobe.clearLine ? '0 : runTotal;
    basePtr      = strobe.clearLine ? '0 : slotPtr;
    nextTotal    = baseTotal + ACC_W'(sampleIn);
    // oldest slot holds the total from WINDOW samples back
    delayedTotal = strobe.useDelayed ? delayStore[basePtr] : '0;
    windowDiff   = nextTotal - delayedTotal;
  end

  generate
    if (WINDOW > 1) begin : gPtrWrap
      always_comb nextPtr = (basePtr == PTR_LAST) ? '0 : basePtr + PTR_W'(1);
    end else begin : gPtrSingle
      always_comb nextPtr = '0;
    end
  endgenerate

  // total and pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runTotal <= '0;
      slotPtr  <= '0;
    end else if (strobe.push) begin
      runTotal <= nextTotal;
      slotPtr  <= nextPtr;
    end else if (strobe.clearLine) begin
      runTotal <= '0;
      slotPtr  <= '0;
    end
  end

  // delay store: no reset needed, reads are gated by useDelayed
  always_ff @(posedge clk) begin
    if (strobe.push) begin
      delayStore[basePtr] <= nextTotal;
    end
  end

  // registered result
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumOut   <= '0;
      sumValid <= 1'b0;
    end else begin
      sumValid <= strobe.push;
      if (strobe.push) begin
        sumOut <= windowDiff[SUM_W-1:0];
      end
    end
  end

endmodule

// File: rtl/boxcar_line_filter.sv
module boxcar_line_filter
  import boxcar_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int WINDOW   = 4,
  parameter int LINE_MAX = 1024,
  localparam int ACC_W   = SAMPLE_W + $clog2(LINE_MAX),
  localparam int SUM_W   = SAMPLE_W + $clog2(WINDOW)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  input  logic                lineStart,
  output logic [SUM_W-1:0]    sumOut,
  output logic                sumValid
);

  boxStrobe_t strobe;

  boxcar_ctrl #(
    .WINDOW(WINDOW)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .lineStart  (lineStart),
    .strobe     (strobe)
  );

  boxcar_dpath #(
    .SAMPLE_W(SAMPLE_W),
    .WINDOW  (WINDOW),
    .ACC_W   (ACC_W),
    .SUM_W   (SUM_W)
  ) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .sampleIn(sampleIn),
    .strobe  (strobe),
    .sumOut  (sumOut),
    .sumValid(sumValid)
  );

endmodule

// File: rtl/boxcar_line_filter_chk.sv
module boxcar_line_filter_chk #(
  parameter int SAMPLE_W = 8,
  parameter int WINDOW   = 4,
  localparam int SUM_W   = SAMPLE_W + $clog2(WINDOW)
) (
  input logic                clk,
  input logic                rstN,
  input logic [SAMPLE_W-1:0] sampleIn,
  input logic                sampleValid,
  input logic                lineStart,
  input logic [SUM_W-1:0]    sumOut,
  input logic                sumValid
);

  localparam int unsigned SUM_LIMIT = WINDOW * ((1 << SAMPLE_W) - 1);

  // R1: a cycle in reset is followed by an idle, cleared output
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (!sumValid && sumOut == '0));

  // R2: one result per accepted sample, one cycle later
  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> sumValid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !sumValid);

  // R6 (and R3): a sample arriving with the line start returns itself
  assert_first_sample_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && lineStart) |=> (sumOut == SUM_W'($past(sampleIn))));

  // R4: never above a full window of maximum values
  assert_sum_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    sumValid |-> (32'(sumOut) <= SUM_LIMIT));

  // R7: a lone line start yields nothing
  assert_lone_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && !sampleValid) |=> !sumValid);

  // R8: output held while no result is produced
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(sumOut));

endmodule

bind boxcar_line_filter boxcar_line_filter_chk #(
  .SAMPLE_W(SAMPLE_W),
  .WINDOW  (WINDOW)
) uChk (.*);

// File: tb/tb_boxcar_line_filter.sv
`timescale 1ns/1ps
module tb_boxcar_line_filter;

  localparam int SAMPLE_W = 8;
  localparam int WINDOW   = 4;
  localparam int LINE_MAX = 16;  // small so the running total wraps (R9)
  localparam int SUM_W    = SAMPLE_W + $clog2(WINDOW);
  localparam int SUM_MASK = (1 << SUM_W) - 1;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [SAMPLE_W-1:0] sampleIn = '0;
  logic                sampleValid = 1'b0;
  logic                lineStart = 1'b0;
  logic [SUM_W-1:0]    sumOut;
  logic                sumValid;

  boxcar_line_filter #(
    .SAMPLE_W(SAMPLE_W),
    .WINDOW  (WINDOW),
    .LINE_MAX(LINE_MAX)
  ) dut (
    .clk        (clk),
    .rstN       (rstN),
    .sampleIn   (sampleIn),
    .sampleValid(sampleValid),
    .lineStart  (lineStart),
    .sumOut     (sumOut),
    .sumValid   (sumValid)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    expSum;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int       lineHist[$];
  int       nChecks = 0;
  int       nFails  = 0;
  bit       runDone = 1'b0;
  bit       monOn   = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, model pushes the expected result
  task automatic drive(input int val, input bit vld, input bit ls, input string tag);
    int s;
    @(posedge clk);
    #1;
    sampleIn    = SAMPLE_W'(val);
    sampleValid = vld;
    lineStart   = ls;
    if (ls) lineHist.delete();
    if (vld) begin
      lineHist.push_back(val);
      s = 0;
      for (int k = 0; k < WINDOW && k < lineHist.size(); k++)
        s += lineHist[lineHist.size() - 1 - k];
      expQ.push_back('{expSum: s & SUM_MASK, tag: tag});
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 1'b0, 1'b0, "");
  endtask

  // monitor: pops and compares at the falling edge
  int lastSum = 0;
  always @(negedge clk) begin
    if (monOn) begin
      if (sumValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected result", int'(sumOut), -1);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(int'(sumOut) == it.expSum, it.tag, int'(sumOut), it.expSum);
        end
      end else begin
        check(int'(sumOut) == lastSum, "R8 hold while idle", int'(sumOut), lastSum);
      end
      lastSum = int'(sumOut);
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!sumValid && sumOut == '0, "R1 in reset", int'(sumOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!sumValid && sumOut == '0, "R1 after reset", int'(sumOut), 0);
    monOn = 1'b1;

    // R3 / R4: partial then full windows
    drive(3, 1'b1, 1'b1, "R3 first sample");
    drive(5, 1'b1, 1'b0, "R3 partial");
    drive(7, 1'b1, 1'b0, "R3 partial");
    drive(11, 1'b1, 1'b0, "R4 full window");
    drive(13, 1'b1, 1'b0, "R4 sliding");
    drive(17, 1'b1, 1'b0, "R4 sliding");

    // R5: gaps inside the window change nothing
    idle(2);
    drive(19, 1'b1, 1'b0, "R5 after gap");
    idle(1);
    drive(23, 1'b1, 1'b0, "R5 after gap");
    drive(29, 1'b1, 1'b0, "R5 sliding");
    idle(3);

    // R6: line start together with a sample, after large values
    for (int i = 0; i < 5; i++) drive(250, 1'b1, 1'b0, "R4 large values");
    drive(2, 1'b1, 1'b1, "R6 start with sample");
    drive(4, 1'b1, 1'b0, "R6 new line partial");
    drive(6, 1'b1, 1'b0, "R6 new line partial");
    drive(8, 1'b1, 1'b0, "R6 new line full");

    // R7: lone line start, then a fresh window
    drive(0, 1'b0, 1'b1, "");
    idle(1);
    drive(9, 1'b1, 1'b0, "R7 fresh window");
    drive(1, 1'b1, 1'b0, "R7 fresh partial");

    // R9: line far beyond LINE_MAX, running total wraps
    drive(255, 1'b1, 1'b1, "R9 wrap start");
    for (int i = 0; i < 40; i++) begin
      drive((i % 3 == 0) ? 255 : 200 + i, 1'b1, 1'b0, "R9 across wrap");
      if (i % 7 == 3) idle(1);
    end
    drive(1, 1'b1, 1'b0, "R9 after wrap");

    idle(4);
    check(expQ.size() == 0, "R2 results outstanding", expQ.size(), 0);
    runDone = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!runDone) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule